// File: doc/BRIEF.md
# Reference-Pulse Capture and Frame Counter Alignment

This block takes an external system-reference pulse into the device clock domain and uses it to set the phase of a local framing counter. The counter runs continuously with a programmable period of K frames and wraps to zero. When an accepted reference event arrives, the counter is forced so that its next value is zero. Several converters or receivers that see the same reference on the same clock edge end up with framing counters in the same phase.

Two capture modes are available. In one-shot mode, capture must first be armed, and only the first event after arming is taken. In recurring mode, every event is compared with the running counter. An event that lands on the counter's natural wrap confirms the alignment and changes nothing. An event that lands anywhere else shows that alignment was lost. It realigns the counter, sets a sticky flag and bumps a saturating realignment count. Separately from all of this, each detected event can raise a one-cycle marker beside the sample stream, and the marker disturbs no state.

Top module: `sysref_align`

## Requirements
- R1: The reference input passes through two sampling flops, and a rising edge is then detected against a further registered copy. If refIn is first sampled high at clock edge n, an accepted event makes frameCnt read 0 after edge n+2, and realignCount changes no earlier than that edge.
- R2: A reference pulse that stays high for several cycles counts as a single event, keyed to its first sampled high cycle.
- R3: With no event, frameCnt counts up by one each cycle and returns to 0 in the cycle after it reaches periodK-1. A periodK of 0 behaves as a period of 1, so frameCnt stays at 0.
- R4: In one-shot mode (modeRecur = 0), an event is taken only while capture is armed. Taking one event disarms capture, so later events are ignored until armIn is pulsed again.
- R5: In recurring mode (modeRecur = 1), the first event after reset aligns the counter. Once aligned, an event that arrives in the cycle where frameCnt equals periodK-1 is ignored: frameCnt, lostSync and realignCount are left unchanged.
- R6: In recurring mode, an aligned event at any other counter phase realigns frameCnt, sets lostSync, and lostSync stays set until reset.
- R7: alignedOut rises with the first accepted event and then stays high until reset.
- R8: When markEn is 1, each detected event drives markerOut high for exactly one cycle, in the cycle after edge n+2. The marker does not reset the counter.
- R9: After reset, frameCnt, alignedOut, lostSync, realignCount and markerOut are 0 and capture is disarmed.
- R10: When armIn and an event fall in the same cycle while capture is already armed, the event is taken and capture stays armed for the next event.
- R11: realignCount rises by one on every accepted event (the first alignment included) and saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refIn | input | 1 | External system-reference pulse |
| modeRecur | input | 1 | 1 = recurring mode, 0 = one-shot mode |
| armIn | input | 1 | Pulse that arms one-shot capture |
| markEn | input | 1 | Enables the event marker |
| periodK | input | CNT_W | Framing counter period in frames |
| frameCnt | output | CNT_W | Framing counter value |
| alignedOut | output | 1 | High once any event has been accepted |
| lostSync | output | 1 | Sticky flag: a phase mismatch was seen |
| realignCount | output | RC_W | Saturating count of realignments |
| markerOut | output | 1 | One-cycle marker for each detected event |

## Verification
Two pairs of events can land in the same cycle. The first pair is a recurring-mode event and the counter's own wrap. The bench spaces pulses exactly periodK cycles apart so that each event coincides with the wrap, and it expects no realignment, no lost flag and no change in count. It then shifts one pulse by a single cycle, so the event misses the wrap, and expects a realignment. The second pair is an arm pulse and a one-shot event. The bench times armIn to the detection cycle while capture is already armed, and it judges the result by a second pulse, which must also be taken. A behavioural model compares every output on every cycle.

// File: rtl/sysref_pkg.sv
package sysref_pkg;
  typedef struct packed {
    logic align;
    logic lostSet;
    logic mark;
  } ctrlStrobe_t;
endpackage

// File: rtl/sysref_sampler.sv
module sysref_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  output logic eventPulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic lastQ;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= refIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[LAST];
  end

  // one strobe per pulse, on its first sampled high cycle
  assign eventPulse = syncQ[LAST] & ~lastQ;
endmodule

// File: rtl/sysref_ctrl.sv
module sysref_ctrl
  import sysref_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        eventPulse,
  input  logic        modeRecur,
  input  logic        armIn,
  input  logic        markEn,
  input  logic        atWrap,
  output ctrlStrobe_t strobe,
  output logic        alignedQ
);
  logic armedQ;
  logic takeOneShot;
  logic takeRecur;

  assign takeOneShot = eventPulse & ~modeRecur & armedQ;
  assign takeRecur   = eventPulse & modeRecur & (~alignedQ | ~atWrap);

  always_comb begin
    strobe.align   = takeOneShot | takeRecur;
    strobe.lostSet = eventPulse & modeRecur & alignedQ & ~atWrap;
    strobe.mark    = eventPulse & markEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ   <= 1'b0;
      alignedQ <= 1'b0;
    end else begin
      if (armIn)            armedQ <= 1'b1;
      else if (takeOneShot) armedQ <= 1'b0;
      if (strobe.align)     alignedQ <= 1'b1;
    end
  end
endmodule

// File: rtl/sysref_datapath.sv
module sysref_datapath
  import sysref_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int RC_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] periodK,
  output logic             atWrap,
  output logic [CNT_W-1:0] frameCnt,
  output logic             lostSync,
  output logic [RC_W-1:0]  realignCount,
  output logic             markerOut
);
  localparam logic [RC_W-1:0] RC_MAX = {RC_W{1'b1}};

  logic [CNT_W:0] nextWide;

  assign nextWide = {1'b0, frameCnt} + {{CNT_W{1'b0}}, 1'b1};
  assign atWrap   = nextWide >= {1'b0, periodK};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt     <= '0;
      lostSync     <= 1'b0;
      realignCount <= '0;
      markerOut    <= 1'b0;
    end else begin
      if (strobe.align || atWrap) frameCnt <= '0;
      else                        frameCnt <= nextWide[CNT_W-1:0];
      if (strobe.align && realignCount != RC_MAX)
        realignCount <= realignCount + 1'b1;
      if (strobe.lostSet) lostSync <= 1'b1;
      markerOut <= strobe.mark;
    end
  end
endmodule

// File: rtl/sysref_align.sv
module sysref_align
  import sysref_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int RC_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             modeRecur,
  input  logic             armIn,
  input  logic             markEn,
  input  logic [CNT_W-1:0] periodK,
  output logic [CNT_W-1:0] frameCnt,
  output logic             alignedOut,
  output logic             lostSync,
  output logic [RC_W-1:0]  realignCount,
  output logic             markerOut
);
  logic        eventPulse;
  logic        atWrap;
  ctrlStrobe_t strobe;

  sysref_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rstN(rstN), .refIn(refIn), .eventPulse(eventPulse)
  );

  sysref_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .eventPulse(eventPulse), .modeRecur(modeRecur),
    .armIn(armIn), .markEn(markEn), .atWrap(atWrap), .strobe(strobe),
    .alignedQ(alignedOut)
  );

  sysref_datapath #(.CNT_W(CNT_W), .RC_W(RC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodK(periodK),
    .atWrap(atWrap), .frameCnt(frameCnt), .lostSync(lostSync),
    .realignCount(realignCount), .markerOut(markerOut)
  );
endmodule

// File: rtl/sysref_align_chk.sv
module sysref_align_chk #(
  parameter int CNT_W = 8,
  parameter int RC_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] periodK,
  input logic [CNT_W-1:0] frameCnt,
  input logic             alignedOut,
  input logic             lostSync,
  input logic [RC_W-1:0]  realignCount,
  input logic             markerOut
);
  // a counter at its last phase always reads zero on the next cycle
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, frameCnt} + 1'b1 >= {1'b0, periodK}) |=> (frameCnt == '0));

  assert_lost_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    lostSync |=> lostSync);

  assert_lost_needs_align_R6: assert property (@(posedge clk) disable iff (!rstN)
    lostSync |-> alignedOut);

  assert_aligned_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    alignedOut |=> alignedOut);

  assert_marker_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    markerOut |=> !markerOut);

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (realignCount == $past(realignCount)) || (realignCount == $past(realignCount) + 1'b1));

  assert_count_moves_aligns_R7: assert property (@(posedge clk) disable iff (!rstN)
    (realignCount != '0) |-> alignedOut);
endmodule

bind sysref_align sysref_align_chk #(.CNT_W(CNT_W), .RC_W(RC_W)) u_chk (
  .clk(clk), .rstN(rstN), .periodK(periodK), .frameCnt(frameCnt),
  .alignedOut(alignedOut), .lostSync(lostSync), .realignCount(realignCount),
  .markerOut(markerOut)
);

// File: tb/tb_sysref_align.sv
`timescale 1ns/1ps
module tb_sysref_align;
  localparam int CW = 8;
  localparam int RW = 8;
  localparam int RCMAX = (1 << RW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0, modeRecur = 1'b0, armIn = 1'b0, markEn = 1'b0;
  logic [CW-1:0] periodK = 8'd6;
  logic [CW-1:0] frameCnt;
  logic alignedOut, lostSync, markerOut;
  logic [RW-1:0] realignCount;

  int checks = 0, fails = 0, cycles = 0;
  int mCnt = 0, mAl = 0, mArm = 0, mLost = 0, mRc = 0, mMark = 0;
  int h1 = 0, h2 = 0, h3 = 0;
  bit done = 0;

  sysref_align #(.CNT_W(CW), .RC_W(RW)) dut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .modeRecur(modeRecur),
    .armIn(armIn), .markEn(markEn), .periodK(periodK), .frameCnt(frameCnt),
    .alignedOut(alignedOut), .lostSync(lostSync), .realignCount(realignCount),
    .markerOut(markerOut)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural model of the requirements, advanced on every rising edge
  always @(posedge clk) begin
    bit ev, atLast, take, late;
    cycles++;
    if (!rstN) begin
      mCnt = 0; mAl = 0; mArm = 0; mLost = 0; mRc = 0; mMark = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      ev = (h2 != 0) && (h3 == 0);
      atLast = (mCnt + 1 >= int'(periodK));
      if (modeRecur) take = ev && (mAl == 0 || !atLast);
      else           take = ev && (mArm != 0);
      late = ev && modeRecur && (mAl != 0) && !atLast;
      mMark = (ev && markEn) ? 1 : 0;
      if (take) begin
        mCnt = 0;
        if (mRc < RCMAX) mRc++;
      end else mCnt = atLast ? 0 : mCnt + 1;
      if (late) mLost = 1;
      if (take) mAl = 1;
      if (armIn) mArm = 1;
      else if (take && !modeRecur) mArm = 0;
      h3 = h2; h2 = h1; h1 = refIn ? 1 : 0;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R3 frameCnt", int'(frameCnt), mCnt);
      chk("R7 alignedOut", int'(alignedOut), mAl);
      chk("R6 lostSync", int'(lostSync), mLost);
      chk("R11 realignCount", int'(realignCount), mRc);
      chk("R8 markerOut", int'(markerOut), mMark);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    refIn = 1'b1; idle(hi);
    refIn = 1'b0; idle(lo);
  endtask

  task automatic doReset();
    rstN = 1'b0; idle(2);
    chk("R9 reset frameCnt", int'(frameCnt), 0);
    chk("R9 reset aligned", int'(alignedOut), 0);
    chk("R9 reset lost", int'(lostSync), 0);
    chk("R9 reset count", int'(realignCount), 0);
    chk("R9 reset marker", int'(markerOut), 0);
    rstN = 1'b1; idle(1);
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // R4: one-shot without arming is ignored
    modeRecur = 1'b0; periodK = 8'd6;
    pulse(1, 10);
    chk("R4 unarmed ignored", int'(realignCount), 0);
    chk("R4 unarmed not aligned", int'(alignedOut), 0);

    // R1, R2: armed capture, three-cycle pulse, exact latency
    armIn = 1'b1; idle(1); armIn = 1'b0; idle(3);
    refIn = 1'b1; idle(1);            // sampled high at edge n
    idle(1);                          // after edge n+1
    chk("R1 no change before n+2", int'(realignCount), 0);
    refIn = 1'b1; idle(1);            // after edge n+2
    chk("R1 counter zero after n+2", int'(frameCnt), 0);
    refIn = 1'b0; idle(10);
    chk("R2 long pulse one event", int'(realignCount), 1);
    chk("R7 aligned after accept", int'(alignedOut), 1);

    // R4: second event after disarm ignored
    pulse(2, 9);
    chk("R4 disarmed ignored", int'(realignCount), 1);

    // R3: period 0 holds counter at zero, then period 3
    periodK = 8'd0; idle(5);
    chk("R3 period zero", int'(frameCnt), 0);
    periodK = 8'd3; idle(7);

    // R10: arm in the detection cycle while already armed
    armIn = 1'b1; idle(1); armIn = 1'b0; idle(2);
    refIn = 1'b1; idle(2);
    armIn = 1'b1; refIn = 1'b0; idle(1);   // arm during the event cycle
    armIn = 1'b0; idle(8);
    chk("R10 collided event taken", int'(realignCount), 2);
    pulse(1, 8);
    chk("R10 still armed", int'(realignCount), 3);

    // R5: recurring mode with pulses exactly on the wrap
    doReset();
    modeRecur = 1'b1; periodK = 8'd8; markEn = 1'b1;
    for (int i = 0; i < 6; i++) pulse(2, 6);
    chk("R5 in-phase ignored", int'(realignCount), 1);
    chk("R5 no lost", int'(lostSync), 0);

    // R6: one pulse shifted by a cycle
    idle(1);
    pulse(2, 6);
    chk("R6 realigned", int'(realignCount), 2);
    chk("R6 lost set", int'(lostSync), 1);
    for (int i = 0; i < 3; i++) pulse(2, 6);
    chk("R6 lost sticky", int'(lostSync), 1);
    chk("R5 new phase held", int'(realignCount), 2);

    // R8: marker off, then on, with no effect on alignment
    markEn = 1'b0;
    for (int i = 0; i < 2; i++) pulse(2, 6);
    markEn = 1'b1;
    pulse(2, 6);
    chk("R8 marker no realign", int'(realignCount), 2);

    // R11: saturation through repeated off-phase pulses
    periodK = 8'd200;
    for (int i = 0; i < 270; i++) pulse(1, 3);
    chk("R11 saturated", int'(realignCount), RCMAX);

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule